// File: doc/BRIEF.md
# Memory Clock-Enable Power State Tracker

This block watches the clock-enable input of a DDR4-style memory device, together with a self-refresh entry strobe, the per-bank open-row flags and a burst-busy flag. From these it keeps a two-bit power state: active, precharge power-down, active power-down or self-refresh. Which low-power state is entered depends on whether any bank holds an open row at the moment clock-enable is sampled low.

In each state the block drives a set of enable flags. These gate the internal clock path, the output drivers and the input buffer groups: the general command and address buffers, the clock pair, the termination control and clock-enable itself. Leaving either power-down state is a plain synchronous decision. Leaving self-refresh starts from a clock-enable rising edge that is captured without the sampling clock and then brought into the clock domain through a two-flop synchronizer. A one-cycle violation pulse reports clock-enable dropping while a read or write burst is in progress.

All pins are plain level signals sampled on the rising edge of `clk`. There is no streaming interface, so no back-pressure applies. Reset is asynchronous and active low.

Top module: `ckepwr_tracker`

## Requirements
- R1: After reset the state is 00 (active), every enable output is 1 and `burst_viol` is 0.
- R2: In active state, an edge that samples `cke_in` low with no bank open and `sre_cmd` low moves the state to 01 (precharge power-down).
- R3: In active state, an edge that samples `cke_in` low while any bit of `bank_open` is 1 moves the state to 10 (active power-down), whatever the value of `sre_cmd`.
- R4: In active state, an edge that samples `cke_in` low with no bank open and `sre_cmd` high moves the state to 11 (self-refresh).
- R5: In state 01 or 10, the first edge that samples `cke_in` high returns the state to 00. While `cke_in` stays low, the state holds.
- R6: In state 11, a rising edge of `cke_in` is captured asynchronously and passes through two synchronizer flops. The state becomes 00 at the third rising `clk` edge after the `cke_in` rise, and stays 11 at the first and second edges.
- R7: In state 00, all six enable outputs are 1.
- R8: In states 01 and 10, `ck_inbuf_en`, `term_inbuf_en` and `cke_inbuf_en` are 1, and `core_clk_en`, `gen_inbuf_en` and `out_drv_en` are 0.
- R9: In state 11, only `cke_inbuf_en` is 1. The other five enables are 0.
- R10: `burst_viol` is 1 for exactly the cycle after an edge that samples state 00, `cke_in` low and `burst_busy` high. At all other times it is 0.
- R11: In state 11, with no `cke_in` rise, changes on `sre_cmd`, `bank_open` and `burst_busy` have no effect: the state stays 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_in | input | 1 | Device clock-enable level |
| sre_cmd | input | 1 | Self-refresh entry command strobe, valid with the clock-enable drop |
| bank_open | input | NUM_BANKS | One bit per bank, 1 when that bank holds an open row |
| burst_busy | input | 1 | 1 while a read or write burst is in progress |
| pwr_state | output | 2 | 00 active, 01 precharge power-down, 10 active power-down, 11 self-refresh |
| core_clk_en | output | 1 | Internal clock path enable |
| gen_inbuf_en | output | 1 | Command, address and data input buffer enable |
| out_drv_en | output | 1 | Output driver enable |
| ck_inbuf_en | output | 1 | Clock pair input buffer enable |
| term_inbuf_en | output | 1 | Termination control input buffer enable |
| cke_inbuf_en | output | 1 | Clock-enable input buffer enable |
| burst_viol | output | 1 | One-cycle pulse on a clock-enable drop during a burst |

## Verification
The assertions assume that `cke_in` changes only away from the rising `clk` edge. They also assume that `bank_open`, `sre_cmd` and `burst_busy` are stable around that edge, and that only a genuine `cke_in` rise during self-refresh makes the wake capture flop fire. The stimulus drives every input on the falling edge. It therefore changes `cke_in` half a period away from sampling, and any rise that occurs while the device is in self-refresh is the event the reference model treats as the wake. Random patterns bias the bank flags toward all-idle half the time, so that all three low-power entries occur often. Directed sequences pin down the three-edge self-refresh exit and the stimulus that must be ignored in self-refresh.

// File: rtl/ckepwr_pkg.sv
package ckepwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE   = 2'b00,
    PS_PRE_PD   = 2'b01,
    PS_ACT_PD   = 2'b10,
    PS_SELF_REF = 2'b11
  } pwr_state_e;

  typedef struct packed {
    logic core_clk;
    logic gen_in;
    logic out_drv;
    logic ck_in;
    logic term_in;
    logic cke_in;
  } buf_en_t;

  function automatic logic is_power_down(pwr_state_e s);
    return (s == PS_PRE_PD) || (s == PS_ACT_PD);
  endfunction

endpackage

// File: rtl/ckepwr_wake_sync.sv
module ckepwr_wake_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_in,
  input  logic in_self_ref,
  output logic wake
);
  localparam int LAST = SYNC_STAGES - 1;

  logic arm_n;
  logic wake_cap;
  logic [LAST:0] stage_q;

  // Capture flop is held clear unless the tracker sits in self-refresh.
  assign arm_n = rst_n & in_self_ref;

  always_ff @(posedge cke_in or negedge arm_n) begin
    if (!arm_n) wake_cap <= 1'b0;
    else        wake_cap <= 1'b1;
  end

  // The chain is flushed whenever the tracker is outside self-refresh.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            stage_q <= '0;
    else if (!in_self_ref) stage_q <= '0;
    else begin
      stage_q[0] <= wake_cap;
      for (int i = 1; i <= LAST; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign wake = stage_q[LAST];

  generate
    if (SYNC_STAGES > 1) begin : g_order
      // R6
      wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(stage_q[LAST-1]));
    end
  endgenerate

endmodule

// File: rtl/ckepwr_state_fsm.sv
module ckepwr_state_fsm
  import ckepwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_in,
  input  logic       sre_cmd,
  input  logic       any_open,
  input  logic       wake,
  output pwr_state_e state
);
  pwr_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_ACTIVE: begin
        if (!cke_in) begin
          if (any_open)     state_nx = PS_ACT_PD;
          else if (sre_cmd) state_nx = PS_SELF_REF;
          else              state_nx = PS_PRE_PD;
        end
      end
      PS_PRE_PD, PS_ACT_PD: begin
        if (cke_in) state_nx = PS_ACTIVE;
      end
      PS_SELF_REF: begin
        if (wake) state_nx = PS_ACTIVE;
      end
      default: state_nx = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_ACTIVE;
    else        state <= state_nx;
  end

  // R3
  apd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACTIVE) && !cke_in && any_open |=> state == PS_ACT_PD);
  // R5
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_power_down(state) && cke_in |=> state == PS_ACTIVE);
  // R11
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SELF_REF) && !wake |=> state == PS_SELF_REF);

endmodule

// File: rtl/ckepwr_buf_gate.sv
module ckepwr_buf_gate
  import ckepwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  output buf_en_t    en
);
  always_comb begin
    en = '1;
    unique case (state)
      PS_ACTIVE: en = '1;
      PS_PRE_PD, PS_ACT_PD: begin
        en.core_clk = 1'b0;
        en.gen_in   = 1'b0;
        en.out_drv  = 1'b0;
      end
      PS_SELF_REF: begin
        en         = '0;
        en.cke_in  = 1'b1;
      end
      default: en = '1;
    endcase
  end

  // R9
  sr_bufs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == PS_SELF_REF |-> en.cke_in && !en.ck_in && !en.term_in && !en.gen_in);
  // R8
  pd_bufs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_power_down(state) |-> en.ck_in && en.term_in && !en.out_drv && !en.core_clk);

endmodule

// File: rtl/ckepwr_viol.sv
module ckepwr_viol
  import ckepwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  input  logic       cke_in,
  input  logic       burst_busy,
  output logic       viol
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= (state == PS_ACTIVE) && !cke_in && burst_busy;
  end

  // R10
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACTIVE) && !cke_in && burst_busy |=> viol);
  // R10
  viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_ACTIVE) |=> !viol);

endmodule

// File: rtl/ckepwr_tracker.sv
module ckepwr_tracker
  import ckepwr_pkg::*;
#(
  parameter int NUM_BANKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_in,
  input  logic                 sre_cmd,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 burst_busy,
  output logic [1:0]           pwr_state,
  output logic                 core_clk_en,
  output logic                 gen_inbuf_en,
  output logic                 out_drv_en,
  output logic                 ck_inbuf_en,
  output logic                 term_inbuf_en,
  output logic                 cke_inbuf_en,
  output logic                 burst_viol
);
  pwr_state_e state;
  buf_en_t    en;
  logic       any_open;
  logic       wake;

  assign any_open = |bank_open;

  ckepwr_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_in      (cke_in),
    .in_self_ref (state == PS_SELF_REF),
    .wake        (wake)
  );

  ckepwr_state_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_in   (cke_in),
    .sre_cmd  (sre_cmd),
    .any_open (any_open),
    .wake     (wake),
    .state    (state)
  );

  ckepwr_buf_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .en    (en)
  );

  ckepwr_viol u_viol (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cke_in     (cke_in),
    .burst_busy (burst_busy),
    .viol       (burst_viol)
  );

  assign pwr_state     = state;
  assign core_clk_en   = en.core_clk;
  assign gen_inbuf_en  = en.gen_in;
  assign out_drv_en    = en.out_drv;
  assign ck_inbuf_en   = en.ck_in;
  assign term_inbuf_en = en.term_in;
  assign cke_inbuf_en  = en.cke_in;

  // R4
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACTIVE) && !cke_in && !any_open && sre_cmd |=> pwr_state == 2'b11);

endmodule

// File: tb/ckepwr_tracker_tb.sv
module ckepwr_tracker_tb_top;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_in = 1'b1, sre_cmd = 1'b0, burst_busy = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [1:0] pwr_state;
  logic core_clk_en, gen_inbuf_en, out_drv_en, ck_inbuf_en, term_inbuf_en, cke_inbuf_en;
  logic burst_viol;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  logic [1:0] m_st = 2'b00;
  logic m_flag = 0, m_s1 = 0, m_s2 = 0, m_viol = 0;

  always #5 clk = ~clk;

  ckepwr_tracker #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_in(cke_in), .sre_cmd(sre_cmd),
    .bank_open(bank_open), .burst_busy(burst_busy), .pwr_state(pwr_state),
    .core_clk_en(core_clk_en), .gen_inbuf_en(gen_inbuf_en), .out_drv_en(out_drv_en),
    .ck_inbuf_en(ck_inbuf_en), .term_inbuf_en(term_inbuf_en), .cke_inbuf_en(cke_inbuf_en),
    .burst_viol(burst_viol));

  function automatic logic [5:0] exp_en(logic [1:0] s);
    // order: core_clk, gen_in, out_drv, ck_in, term_in, cke_in
    case (s)
      2'b00:   return 6'b111111;
      2'b01,
      2'b10:   return 6'b000111;
      default: return 6'b000001;
    endcase
  endfunction

  function automatic logic [1:0] next_st(logic [1:0] s, logic cke, logic sre,
                                         logic open_any, logic wk);
    case (s)
      2'b00:   return cke ? 2'b00 : (open_any ? 2'b10 : (sre ? 2'b11 : 2'b01));
      2'b01,
      2'b10:   return cke ? 2'b00 : s;
      default: return wk ? 2'b00 : 2'b11;
    endcase
  endfunction

  // reference model steps on every rising edge, using pre-edge values
  always @(posedge clk) begin
    if (rst_n) begin
      logic [1:0] nx;
      nx = next_st(m_st, cke_in, sre_cmd, |bank_open, m_s2);
      m_viol <= (m_st == 2'b00) && !cke_in && burst_busy;
      if (m_st != 2'b11) begin m_s1 <= 0; m_s2 <= 0; end
      else begin m_s2 <= m_s1; m_s1 <= m_flag; end
      m_st <= nx;
      if (nx != 2'b11) m_flag <= 0;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    string st_tag;
    string en_tag;
    case (m_st)
      2'b00: begin st_tag = "R5"; en_tag = "R7"; end
      2'b01: begin st_tag = "R2"; en_tag = "R8"; end
      2'b10: begin st_tag = "R3"; en_tag = "R8"; end
      default: begin st_tag = "R4"; en_tag = "R9"; end
    endcase
    chk(st_tag, {6'd0, pwr_state}, {6'd0, m_st});
    chk(en_tag, {2'd0, core_clk_en, gen_inbuf_en, out_drv_en, ck_inbuf_en,
                 term_inbuf_en, cke_inbuf_en}, {2'd0, exp_en(m_st)});
    chk("R10", {7'd0, burst_viol}, {7'd0, m_viol});
  endtask

  // drive on the falling edge, after checking
  task automatic drive(logic cke, logic sre, logic [NB-1:0] bo, logic busy);
    if (cke && !cke_in && m_st == 2'b11) m_flag = 1;
    cke_in = cke; sre_cmd = sre; bank_open = bo; burst_busy = busy;
  endtask

  task automatic step(logic cke, logic sre, logic [NB-1:0] bo, logic busy);
    @(negedge clk);
    check_all();
    drive(cke, sre, bo, busy);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", {6'd0, pwr_state}, 8'h00);
    chk("R1", {2'd0, core_clk_en, gen_inbuf_en, out_drv_en, ck_inbuf_en,
               term_inbuf_en, cke_inbuf_en}, 8'h3f);
    chk("R1", {7'd0, burst_viol}, 8'h00);
    rst_n = 1'b1;

    // R2 precharge power-down entry and R5 exit
    step(0, 0, '0, 0);
    step(0, 0, '0, 0);
    chk("R2", {6'd0, pwr_state}, 8'h01);
    step(1, 0, '0, 0);
    step(1, 0, '0, 0);
    chk("R5", {6'd0, pwr_state}, 8'h00);

    // R3 open bank wins over sre, with burst violation R10
    step(0, 1, 16'h0100, 1);
    @(negedge clk);
    chk("R3", {6'd0, pwr_state}, 8'h02);
    chk("R10", {7'd0, burst_viol}, 8'h01);
    check_all();
    drive(1, 0, '0, 0);
    step(1, 0, '0, 0);

    // R4 self-refresh entry, R11 ignore, R6 exit timing
    step(0, 1, '0, 0);
    step(0, 0, 16'hffff, 1);
    chk("R4", {6'd0, pwr_state}, 8'h03);
    for (int k = 0; k < 4; k++) begin
      step(0, k[0], 16'(k * 16'h1111), k[1]);
      chk("R11", {6'd0, pwr_state}, 8'h03);
    end
    step(1, 0, '0, 0);       // cke rises here
    @(negedge clk); check_all();
    chk("R6", {6'd0, pwr_state}, 8'h03);
    @(negedge clk); check_all();
    chk("R6", {6'd0, pwr_state}, 8'h03);
    @(negedge clk); check_all();
    chk("R6", {6'd0, pwr_state}, 8'h00);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic c, s, b;
      logic [NB-1:0] bo;
      c  = ($urandom % 10) < 7;
      s  = ($urandom % 3) == 0;
      b  = ($urandom % 4) == 0;
      bo = ($urandom % 2) ? NB'($urandom) : '0;
      step(c, s, bo, b);
    end
    @(negedge clk);
    check_all();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule